// File: doc/BRIEF.md
# Vertical Scroll Line Mapper

This block translates a display scan line number into the frame-memory line that must be shown on that scan line while hardware vertical scrolling is active. The panel is split into three horizontal bands. A fixed band at the top and a fixed band at the bottom pass straight through. A middle band is rotated by a programmable offset, and it wraps around inside its own height.

The band sizes and the offset are loaded from the host command byte stream. A band-definition command (code 0x33) is followed by six parameter bytes. A scroll-start command (code 0x37) is followed by two parameter bytes. The parameter registers live inside the block.

A scan-timing engine presents one display line index per cycle with a valid strobe. The block returns the mapped frame-memory line one clock later. When the programmed bands are inconsistent, the block falls back to a plain identity mapping, so that a half-written setup never shows a torn image.

The command parser is a three-state machine:
- `PS_IDLE`: waiting for a command code.
- `PS_DEF`: collecting band-definition bytes.
- `PS_SSA`: collecting scroll-start bytes.

Its transitions are:
- *take-def*: any state to `PS_DEF` on code 0x33.
- *take-start*: any state to `PS_SSA` on code 0x37.
- *drop*: any state to `PS_IDLE` on any other code.
- *commit-def*: `PS_DEF` to `PS_IDLE` on the sixth parameter byte.
- *commit-start*: `PS_SSA` to `PS_IDLE` on the second parameter byte.
- *stay*: a parameter byte in `PS_IDLE`, or a non-final parameter byte, keeps the current state.

Top module: `vsm_scroll_mapper`

## Requirements
- R1: After reset, the configuration is: top band 0, scroll band PANEL_LINES, bottom band 0, scroll start 0. Every line maps to itself, and `map_valid` is low.
- R2: A command byte (`cmd_is_op`=1) of value 0x33 is followed by six parameter bytes (`cmd_is_op`=0). These form three 16-bit values, high byte first, in this order: top band height, scroll band height, bottom band height. All three take effect together on the sixth byte and not before.
- R3: A command byte of value 0x37 is followed by two parameter bytes, high byte first. They form the frame-memory line shown directly below the top band, and take effect on the second byte.
- R4: A display line d below the top band height T maps to d.
- R5: A display line d at or beyond T+V, where V is the scroll band height, maps to d.
- R6: When the configuration is consistent, a display line d with T <= d < T+V maps to T + ((S - T) + (d - T)) mod V, where S is the scroll start.
- R7: `map_line` holds the result for the `line_idx` presented one clock earlier, and `map_valid` equals `line_valid` delayed by one clock.
- R8: The configuration is consistent only if all of the following hold: T+V+B equals PANEL_LINES, V is nonzero, and T <= S < T+V. Otherwise every line maps to itself.
- R9: A command byte arriving before a parameter sequence is complete discards the partial sequence. The registers of the abandoned command keep their previous values.
- R10: Parameter bytes received outside a sequence, parameter bytes after a command code other than 0x33 or 0x37, and cycles with `cmd_valid` low all leave the mapping unchanged.
- R11: For any input line below PANEL_LINES, the mapped line is below PANEL_LINES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command-stream byte is present this cycle |
| cmd_is_op | input | 1 | 1: the byte is a command code; 0: the byte is a parameter |
| cmd_byte | input | 8 | Command-stream byte |
| line_valid | input | 1 | A display line index is present this cycle |
| line_idx | input | 16 | Display line index |
| map_valid | output | 1 | `map_line` carries a result |
| map_line | output | 16 | Frame-memory line for the index of the previous cycle |

## Verification
The bench sweeps every display line of a 16-line panel over every scroll start and a grid of top and bottom band heights. This exposes two kinds of error in the wrap arithmetic:
- an off-by-one at the wrap point, which would repeat or skip one memory line at the band seam;
- a modulo taken against the panel height instead of the band height, which would leak memory lines from the fixed bands into the scrolled image.

Start values just outside the band, mismatched band sums and a zero-height band are driven to show that a design lacking the consistency check would map lines outside the band or beyond the panel. Definition sequences that are cut short, padded with extra bytes, or interleaved with foreign commands target a parser that commits early or shifts stale bytes into a register.

// File: rtl/vsm_pkg.sv
package vsm_pkg;

    localparam int unsigned LINE_W    = 16;
    localparam int unsigned DEF_BYTES = 6;
    localparam int unsigned SSA_BYTES = 2;

    localparam logic [7:0] OP_SCROLL_DEF   = 8'h33;
    localparam logic [7:0] OP_SCROLL_START = 8'h37;

    typedef logic [LINE_W-1:0] line_t;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_DEF,
        PS_SSA
    } parse_state_t;

    typedef struct packed {
        line_t top_lines;
        line_t scroll_lines;
        line_t bottom_lines;
        line_t scroll_start;
    } scroll_cfg_t;

endpackage

// File: rtl/vsm_cmd_parser.sv
module vsm_cmd_parser
    import vsm_pkg::*;
#(
    parameter int unsigned PANEL_LINES = 320
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic        cmd_is_op,
    input  logic [7:0]  cmd_byte,
    output scroll_cfg_t cfg_q
);

    localparam int unsigned CNT_W = $clog2(DEF_BYTES + 1);
    localparam int unsigned ACC_W = 8 * (DEF_BYTES - 1);

    parse_state_t       st_q, st_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [ACC_W-1:0]   acc_q;

    logic op_byte, param_byte, def_last, ssa_last;

    assign op_byte    = cmd_valid &&  cmd_is_op;
    assign param_byte = cmd_valid && !cmd_is_op;
    assign def_last   = (st_q == PS_DEF) && param_byte && (cnt_q == CNT_W'(DEF_BYTES - 1));
    assign ssa_last   = (st_q == PS_SSA) && param_byte && (cnt_q == CNT_W'(SSA_BYTES - 1));

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (op_byte) begin
            if (cmd_byte == OP_SCROLL_DEF)
                st_d = PS_DEF;
            else if (cmd_byte == OP_SCROLL_START)
                st_d = PS_SSA;
            else
                st_d = PS_IDLE;
        end else if (param_byte) begin
            unique case (st_q)
                PS_IDLE: st_d = PS_IDLE;
                PS_DEF:  st_d = def_last ? PS_IDLE : PS_DEF;
                PS_SSA:  st_d = ssa_last ? PS_IDLE : PS_SSA;
                default: st_d = PS_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= PS_IDLE;
        else
            st_q <= st_d;
    end

    // byte collection and register commit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q              <= '0;
            acc_q              <= '0;
            cfg_q.top_lines    <= '0;
            cfg_q.scroll_lines <= LINE_W'(PANEL_LINES);
            cfg_q.bottom_lines <= '0;
            cfg_q.scroll_start <= '0;
        end else if (op_byte) begin
            cnt_q <= '0;
        end else if (param_byte && (st_q != PS_IDLE)) begin
            cnt_q <= cnt_q + 1'b1;
            acc_q <= {acc_q[ACC_W-9:0], cmd_byte};
            if (def_last) begin
                cfg_q.top_lines    <= acc_q[ACC_W-1 -: LINE_W];
                cfg_q.scroll_lines <= acc_q[ACC_W-1-LINE_W -: LINE_W];
                cfg_q.bottom_lines <= {acc_q[7:0], cmd_byte};
            end
            if (ssa_last)
                cfg_q.scroll_start <= {acc_q[7:0], cmd_byte};
        end
    end

endmodule

// File: rtl/vsm_cfg_check.sv
module vsm_cfg_check
    import vsm_pkg::*;
#(
    parameter int unsigned PANEL_LINES = 320
) (
    input  scroll_cfg_t       cfg,
    output logic              cfg_ok,
    output logic [LINE_W:0]   scroll_end
);

    localparam logic [LINE_W+1:0] PANEL_EXT = (LINE_W + 2)'(PANEL_LINES);

    logic [LINE_W+1:0] total;

    always_comb begin
        scroll_end = {1'b0, cfg.top_lines} + {1'b0, cfg.scroll_lines};
        total      = {2'b00, cfg.top_lines} + {2'b00, cfg.scroll_lines}
                   + {2'b00, cfg.bottom_lines};
        cfg_ok     = (total == PANEL_EXT)
                  && (cfg.scroll_lines != '0)
                  && (cfg.scroll_start >= cfg.top_lines)
                  && ({1'b0, cfg.scroll_start} < scroll_end);
    end

endmodule

// File: rtl/vsm_line_map.sv
module vsm_line_map
    import vsm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  scroll_cfg_t     cfg,
    input  logic            cfg_ok,
    input  logic [LINE_W:0] scroll_end,
    input  logic            line_valid,
    input  line_t           line_idx,
    output logic            map_valid,
    output line_t           map_line
);

    logic            in_band;
    logic [LINE_W:0] phase, step, raw, wrapped;
    line_t           target, map_next;

    always_comb begin
        in_band  = (line_idx >= cfg.top_lines) && ({1'b0, line_idx} < scroll_end);
        phase    = {1'b0, cfg.scroll_start - cfg.top_lines};
        step     = {1'b0, line_idx - cfg.top_lines};
        raw      = phase + step;
        wrapped  = (raw >= {1'b0, cfg.scroll_lines}) ? raw - {1'b0, cfg.scroll_lines} : raw;
        target   = cfg.top_lines + wrapped[LINE_W-1:0];
        map_next = (cfg_ok && in_band) ? target : line_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_valid <= 1'b0;
            map_line  <= '0;
        end else begin
            map_valid <= line_valid;
            if (line_valid)
                map_line <= map_next;
        end
    end

endmodule

// File: rtl/vsm_scroll_mapper.sv
module vsm_scroll_mapper
    import vsm_pkg::*;
#(
    parameter int unsigned PANEL_LINES = 320
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic        cmd_is_op,
    input  logic [7:0]  cmd_byte,
    input  logic        line_valid,
    input  logic [15:0] line_idx,
    output logic        map_valid,
    output logic [15:0] map_line
);

    scroll_cfg_t     cfg_q;
    logic            cfg_ok;
    logic [LINE_W:0] scroll_end;

    vsm_cmd_parser #(.PANEL_LINES(PANEL_LINES)) i_parser (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_is_op (cmd_is_op),
        .cmd_byte  (cmd_byte),
        .cfg_q     (cfg_q)
    );

    vsm_cfg_check #(.PANEL_LINES(PANEL_LINES)) i_check (
        .cfg        (cfg_q),
        .cfg_ok     (cfg_ok),
        .scroll_end (scroll_end)
    );

    vsm_line_map i_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg_q),
        .cfg_ok     (cfg_ok),
        .scroll_end (scroll_end),
        .line_valid (line_valid),
        .line_idx   (line_idx),
        .map_valid  (map_valid),
        .map_line   (map_line)
    );

endmodule

// File: rtl/vsm_checker.sv
module vsm_checker
    import vsm_pkg::*;
#(
    parameter int unsigned PANEL_LINES = 320
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic            line_valid,
    input line_t           line_idx,
    input logic            map_valid,
    input line_t           map_line,
    input scroll_cfg_t     cfg_q,
    input logic            cfg_ok,
    input logic [LINE_W:0] scroll_end
);

    localparam line_t PANEL_L = LINE_W'(PANEL_LINES);

    p_valid_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |=> map_valid);

    p_valid_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !line_valid |=> !map_valid);

    p_top_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && (line_idx < cfg_q.top_lines)) |=> (map_line == $past(line_idx)));

    p_bottom_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && ({1'b0, line_idx} >= scroll_end)) |=> (map_line == $past(line_idx)));

    p_band_stay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && cfg_ok && (line_idx >= cfg_q.top_lines) && ({1'b0, line_idx} < scroll_end))
        |=> ((map_line >= $past(cfg_q.top_lines)) && ({1'b0, map_line} < $past(scroll_end))));

    p_fallback_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && !cfg_ok) |=> (map_line == $past(line_idx)));

    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(cfg_q));

    p_in_panel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && (line_idx < PANEL_L)) |=> (map_line < PANEL_L));

endmodule

bind vsm_scroll_mapper vsm_checker #(.PANEL_LINES(PANEL_LINES)) i_vsm_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .line_valid (line_valid),
    .line_idx   (line_idx),
    .map_valid  (map_valid),
    .map_line   (map_line),
    .cfg_q      (cfg_q),
    .cfg_ok     (cfg_ok),
    .scroll_end (scroll_end)
);

// File: tb/test_vsm_scroll_mapper.sv
`timescale 1ns/1ps
module test_vsm_scroll_mapper;

    localparam int P = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_is_op = 1'b0;
    logic [7:0]  cmd_byte = 8'h00;
    logic        line_valid = 1'b0;
    logic [15:0] line_idx = 16'h0;
    logic        map_valid;
    logic [15:0] map_line;

    int n_cmp = 0;
    int n_bad = 0;
    int cur_t = 0, cur_v = P, cur_b = 0, cur_s = 0;

    always #2 clk = ~clk;

    vsm_scroll_mapper #(.PANEL_LINES(P)) i_vsm_scroll_mapper (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_op(cmd_is_op),
        .cmd_byte(cmd_byte), .line_valid(line_valid), .line_idx(line_idx),
        .map_valid(map_valid), .map_line(map_line)
    );

    function automatic bit cfg_good(int t, int v, int b, int s);
        return (t + v + b == P) && (v != 0) && (s >= t) && (s < t + v);
    endfunction

    function automatic int exp_map(int t, int v, int b, int s, int d);
        if (!cfg_good(t, v, b, s)) return d;
        if (d < t || d >= t + v) return d;
        return t + (((s - t) + (d - t)) % v);
    endfunction

    function automatic string req_of(int t, int v, int b, int s, int d);
        if (!cfg_good(t, v, b, s)) return "R8";
        if (d < t) return "R4";
        if (d >= t + v) return "R5";
        return "R6";
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic put(bit is_op, logic [7:0] b);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_is_op = is_op; cmd_byte = b;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic set_def(int t, int v, int b);
        put(1'b1, 8'h33);
        put(1'b0, t[15:8]); put(1'b0, t[7:0]);
        put(1'b0, v[15:8]); put(1'b0, v[7:0]);
        put(1'b0, b[15:8]); put(1'b0, b[7:0]);
        cur_t = t; cur_v = v; cur_b = b;
    endtask

    task automatic set_start(int s);
        put(1'b1, 8'h37);
        put(1'b0, s[15:8]); put(1'b0, s[7:0]);
        cur_s = s;
    endtask

    task automatic look(int d, string req, int expv);
        @(negedge clk);
        line_valid = 1'b1; line_idx = 16'(d);
        @(negedge clk);
        check(map_valid === 1'b1, {req, "/R7 valid"}, int'(map_valid), 1);
        check(map_line == 16'(expv), req, int'(map_line), expv);
        line_valid = 1'b0;
    endtask

    task automatic sweep(string tag);
        for (int d = 0; d < P; d++) begin
            string r;
            r = (tag.len() != 0) ? tag : req_of(cur_t, cur_v, cur_b, cur_s, d);
            look(d, r, exp_map(cur_t, cur_v, cur_b, cur_s, d));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(map_valid === 1'b0, "R1 valid in reset", int'(map_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(map_valid === 1'b0, "R1 valid after reset", int'(map_valid), 0);
        sweep("R1");

        // R7: valid drops one cycle after line_valid falls
        look(5, "R7", 5);
        @(negedge clk);
        check(map_valid === 1'b0, "R7 drop", int'(map_valid), 0);

        // R10: stray parameter bytes and a foreign command leave mapping alone
        put(1'b0, 8'h00); put(1'b0, 8'h05);
        put(1'b1, 8'h2C); put(1'b0, 8'h00); put(1'b0, 8'h07);
        sweep("R10");

        // R2, R3, R4, R5, R6, R8: exhaustive grid
        for (int t = 0; t <= 5; t++)
            for (int b = 0; b <= 5; b++) begin
                set_def(t, P - t - b, b);
                for (int s = 0; s < P; s++) begin
                    set_start(s);
                    sweep("");
                end
            end

        // R8: sums that miss the panel, zero-height band
        set_def(2, 10, 2); set_start(4); sweep("R8");
        set_def(8, 0, 8);  set_start(8); sweep("R8");
        set_def(3, 10, 4); set_start(5); sweep("R8");

        // R2: definition applies only on the sixth byte
        set_def(2, 10, 4); set_start(6);
        put(1'b1, 8'h33);
        put(1'b0, 8'h00); put(1'b0, 8'h04);
        put(1'b0, 8'h00); put(1'b0, 8'h08);
        put(1'b0, 8'h00);
        sweep("R2");
        put(1'b0, 8'h04);
        cur_t = 4; cur_v = 8; cur_b = 4;
        sweep("R2");

        // R9: interrupted definition keeps old bands, new start still applies
        put(1'b1, 8'h33);
        put(1'b0, 8'h00); put(1'b0, 8'h01); put(1'b0, 8'h00);
        set_start(9);
        sweep("R9");
        // R9: interrupted start keeps old start
        put(1'b1, 8'h37); put(1'b0, 8'h00);
        put(1'b1, 8'h00);
        put(1'b0, 8'h0A);
        sweep("R9");

        // R10: extra bytes after a finished definition are ignored
        set_def(1, 14, 1); set_start(3);
        put(1'b0, 8'hFF); put(1'b0, 8'hFF);
        sweep("R10");

        // R11: mapped line stays in panel for a tight wrap
        set_def(0, 16, 0); set_start(15);
        for (int d = 0; d < P; d++) begin
            look(d, "R11", (15 + d) % 16);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule